// File: doc/BRIEF.md
# Cache Main-Pipe Request Arbiter

This block sits at the entry of a data cache main pipeline and chooses at most one request per cycle. Four kinds of request compete: stores, atomics, coherence probes and line replacements. Each kind first lands in its own holding register, so the choice is made only from registered state and not from the long paths that produce the requests. The replace request is picked from a bank of miss entries (lowest index wins) before it is registered. The chosen request and its set index go out, so the set-conflict check downstream can start from them.

The arbiter also applies blocking rules between the request kinds. An eligible refill stops every grant. A valid request in pipeline stage 1 holds back the replace request. A reservation-set update holds back probes in the cycle that follows it. The block also tracks which miss entries have a replace in flight. A refill for such an entry is not allowed to go until stage 3 reports that the replace has finished.

Top module: `mp_entry_arb`

## Requirements
- R1: After synchronous reset, all holding registers are empty: `sel_valid` is 0, and `st_ready`, `amo_ready`, `prb_ready` and `refill_ready` are 1.
- R2: A holding register takes a new request only when it is empty or is being granted in the same cycle. Its ready is 0 otherwise. A held request stays unchanged until it is granted.
- R3: Among eligible held requests, the grant goes to probe first, then replace, then atomic, then store. `sel_src` reports the winner: 0 store, 1 atomic, 2 replace, 3 probe. At most one request is granted per cycle.
- R4: When `sel_valid` is 1, `sel_set` and `sel_data` equal the set index and payload of the granted held request.
- R5: A refill is eligible when `refill_valid` is 1 and `refill_ready` is 1. While a refill is eligible, no request is granted, whatever the set indices are.
- R6: While `s1_valid` is 1, the replace request is not granted. Other sources are unaffected.
- R7: In the cycle after `resv_update` is 1, the probe request is not granted.
- R8: The replace request is taken from the lowest-index miss entry with `miss_rep_valid` set. Its payload is that entry index, zero-extended. `miss_rep_ready` is one-hot on that entry when the replace register accepts, and all zero otherwise.
- R9: `refill_ready` is 0 for a miss entry whose replace is waiting in its register. It is also 0 from the cycle after that replace is granted until the cycle after `s3_rep_done` reports that entry in `s3_rep_id`.
- R10: A holding register granted in a cycle in which its source offers a new request captures the new request with no empty cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request offered |
| st_ready | output | 1 | Store holding register accepts |
| st_set | input | MP_SET_W | Store set index |
| st_data | input | MP_DATA_W | Store payload |
| amo_valid | input | 1 | Atomic request offered |
| amo_ready | output | 1 | Atomic holding register accepts |
| amo_set | input | MP_SET_W | Atomic set index |
| amo_data | input | MP_DATA_W | Atomic payload |
| prb_valid | input | 1 | Probe request offered |
| prb_ready | output | 1 | Probe holding register accepts |
| prb_set | input | MP_SET_W | Probe set index |
| prb_data | input | MP_DATA_W | Probe payload |
| miss_rep_valid | input | MP_NMISS | Per miss entry: replace wanted |
| miss_rep_set | input | MP_NMISS x MP_SET_W | Per miss entry: set index to replace |
| miss_rep_ready | output | MP_NMISS | One-hot: entry whose replace is taken |
| refill_valid | input | 1 | Refill request present |
| refill_id | input | MP_ID_W | Miss entry of the refill |
| refill_ready | output | 1 | Refill allowed for `refill_id` |
| s1_valid | input | 1 | Pipeline stage 1 holds a request |
| s3_rep_done | input | 1 | Stage 3 finished a replace |
| s3_rep_id | input | MP_ID_W | Miss entry of the finished replace |
| resv_update | input | 1 | Reservation set updated this cycle |
| sel_valid | output | 1 | A request is granted this cycle |
| sel_src | output | 2 | Source of the granted request |
| sel_set | output | MP_SET_W | Set index of the granted request |
| sel_data | output | MP_DATA_W | Payload of the granted request |

## Verification
Directed sequences fill all four holding registers at once and then remove the blockers one at a time: reservation update together with stage 1 busy, then an eligible refill, then nothing. Each step shows whether the blocking terms are gated separately or are mixed up with the fixed priority. A replace-then-refill sequence on one miss entry tells a refill that is correctly held until stage 3 reports completion from one released too early or too late. Seeded random traffic then drives every source at once, with sparse miss-entry masks and random refill and completion identities. Checking every cycle against a bench model separates lowest-index miss selection, same-cycle refill of a granted register, and correct payload routing from near-miss variants.

// File: rtl/mp_arb_pkg.sv
`timescale 1ns/1ps
package mp_arb_pkg;

    localparam int MP_SET_W  = 8;
    localparam int MP_DATA_W = 16;
    localparam int MP_NMISS  = 16;
    localparam int MP_ID_W   = $clog2(MP_NMISS);
    localparam int MP_NSRC   = 4;

    // source slot indices; a higher index wins arbitration
    localparam int IX_STORE = 0;
    localparam int IX_ATOM  = 1;
    localparam int IX_REPL  = 2;
    localparam int IX_PROBE = 3;

    typedef enum logic [1:0] {
        SRC_STORE = 2'd0,
        SRC_ATOM  = 2'd1,
        SRC_REPL  = 2'd2,
        SRC_PROBE = 2'd3
    } mp_src_e;

    typedef struct packed {
        logic [MP_SET_W-1:0]  set;
        logic [MP_DATA_W-1:0] data;
    } mp_req_t;

    // one-hot of the highest set bit
    function automatic logic [MP_NSRC-1:0] mp_pick_top(input logic [MP_NSRC-1:0] elig);
        logic [MP_NSRC-1:0] g;
        g = '0;
        for (int i = 0; i < MP_NSRC; i++) begin
            if (elig[i]) begin
                g    = '0;
                g[i] = 1'b1;
            end
        end
        return g;
    endfunction

    function automatic mp_src_e mp_src_of(input logic [MP_NSRC-1:0] onehot);
        mp_src_e s;
        s = SRC_STORE;
        for (int i = 0; i < MP_NSRC; i++) begin
            if (onehot[i]) s = mp_src_e'(i);
        end
        return s;
    endfunction

endpackage

// File: rtl/mp_req_slot.sv
`timescale 1ns/1ps
module mp_req_slot
    import mp_arb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  mp_req_t in_req,
    output logic    in_ready,
    input  logic    grant,
    output logic    slot_valid,
    output mp_req_t slot_req
);

    assign in_ready = !slot_valid || grant;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_valid <= 1'b0;
            slot_req   <= '0;
        end else if (in_valid && in_ready) begin
            slot_valid <= 1'b1;
            slot_req   <= in_req;
        end else if (grant) begin
            slot_valid <= 1'b0;
        end
    end

    // R2
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_valid && !grant) |=> (slot_valid && $stable(slot_req)));

    // R10
    refill_no_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (grant && in_valid) |=> slot_valid);

    // R3
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        grant |-> slot_valid);

endmodule

// File: rtl/mp_miss_pick.sv
`timescale 1ns/1ps
module mp_miss_pick
    import mp_arb_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic [MP_NMISS-1:0]                cand_valid,
    input  logic [MP_NMISS-1:0][MP_SET_W-1:0]  cand_set,
    input  logic                               take,
    output logic                               any,
    output mp_req_t                            pick_req,
    output logic [MP_NMISS-1:0]                cand_ready
);

    logic [MP_ID_W-1:0] pick_id;

    always_comb begin
        any     = 1'b0;
        pick_id = '0;
        for (int i = MP_NMISS - 1; i >= 0; i--) begin
            if (cand_valid[i]) begin
                any     = 1'b1;
                pick_id = MP_ID_W'(i);
            end
        end
    end

    always_comb begin
        pick_req.set  = cand_set[pick_id];
        pick_req.data = MP_DATA_W'(pick_id);
    end

    for (genvar g = 0; g < MP_NMISS; g++) begin : g_rdy
        assign cand_ready[g] = take && any && (pick_id == MP_ID_W'(g));
    end

    // R8
    miss_ready_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cand_ready));

    // R8
    miss_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        (cand_ready != '0) |-> ((cand_valid & (cand_ready - 1'b1)) == '0));

endmodule

// File: rtl/mp_refill_gate.sv
`timescale 1ns/1ps
module mp_refill_gate
    import mp_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rep_grant,
    input  logic               rep_held,
    input  logic [MP_ID_W-1:0] rep_id,
    input  logic               s3_done,
    input  logic [MP_ID_W-1:0] s3_id,
    input  logic               refill_valid,
    input  logic [MP_ID_W-1:0] refill_id,
    output logic               refill_ready,
    output logic               refill_go
);

    logic [MP_NMISS-1:0] pend;

    for (genvar g = 0; g < MP_NMISS; g++) begin : g_pend
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[g] <= 1'b0;
            end else if (rep_grant && rep_id == MP_ID_W'(g)) begin
                pend[g] <= 1'b1;
            end else if (s3_done && s3_id == MP_ID_W'(g)) begin
                pend[g] <= 1'b0;
            end
        end
    end

    assign refill_ready = !pend[refill_id] && !(rep_held && rep_id == refill_id);
    assign refill_go    = refill_valid && refill_ready;

    // R9
    refill_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rep_grant |=> ((refill_id != $past(rep_id)) || !refill_ready));

    // R9
    held_replace_chk: assert property (@(posedge clk) disable iff (rst)
        (rep_held && refill_id == rep_id) |-> !refill_go);

endmodule

// File: rtl/mp_entry_arb.sv
`timescale 1ns/1ps
module mp_entry_arb
    import mp_arb_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               st_valid,
    output logic                               st_ready,
    input  logic [MP_SET_W-1:0]                st_set,
    input  logic [MP_DATA_W-1:0]               st_data,
    input  logic                               amo_valid,
    output logic                               amo_ready,
    input  logic [MP_SET_W-1:0]                amo_set,
    input  logic [MP_DATA_W-1:0]               amo_data,
    input  logic                               prb_valid,
    output logic                               prb_ready,
    input  logic [MP_SET_W-1:0]                prb_set,
    input  logic [MP_DATA_W-1:0]               prb_data,
    input  logic [MP_NMISS-1:0]                miss_rep_valid,
    input  logic [MP_NMISS-1:0][MP_SET_W-1:0]  miss_rep_set,
    output logic [MP_NMISS-1:0]                miss_rep_ready,
    input  logic                               refill_valid,
    input  logic [MP_ID_W-1:0]                 refill_id,
    output logic                               refill_ready,
    input  logic                               s1_valid,
    input  logic                               s3_rep_done,
    input  logic [MP_ID_W-1:0]                 s3_rep_id,
    input  logic                               resv_update,
    output logic                               sel_valid,
    output logic [1:0]                         sel_src,
    output logic [MP_SET_W-1:0]                sel_set,
    output logic [MP_DATA_W-1:0]               sel_data
);

    logic [MP_NSRC-1:0] in_v, in_rdy, slot_v, elig, grant;
    mp_req_t            in_req   [MP_NSRC];
    mp_req_t            slot_req [MP_NSRC];
    mp_req_t            rep_pick;
    logic               rep_any;
    logic               refill_go;
    logic               resv_q;

    // candidate inputs per slot
    always_comb begin
        in_v[IX_STORE]          = st_valid;
        in_req[IX_STORE].set    = st_set;
        in_req[IX_STORE].data   = st_data;
        in_v[IX_ATOM]           = amo_valid;
        in_req[IX_ATOM].set     = amo_set;
        in_req[IX_ATOM].data    = amo_data;
        in_v[IX_REPL]           = rep_any;
        in_req[IX_REPL]         = rep_pick;
        in_v[IX_PROBE]          = prb_valid;
        in_req[IX_PROBE].set    = prb_set;
        in_req[IX_PROBE].data   = prb_data;
    end

    mp_miss_pick u_pick (
        .clk        (clk),
        .rst        (rst),
        .cand_valid (miss_rep_valid),
        .cand_set   (miss_rep_set),
        .take       (in_rdy[IX_REPL]),
        .any        (rep_any),
        .pick_req   (rep_pick),
        .cand_ready (miss_rep_ready)
    );

    for (genvar g = 0; g < MP_NSRC; g++) begin : g_slot
        mp_req_slot u_slot (
            .clk        (clk),
            .rst        (rst),
            .in_valid   (in_v[g]),
            .in_req     (in_req[g]),
            .in_ready   (in_rdy[g]),
            .grant      (grant[g]),
            .slot_valid (slot_v[g]),
            .slot_req   (slot_req[g])
        );
    end

    mp_refill_gate u_gate (
        .clk          (clk),
        .rst          (rst),
        .rep_grant    (grant[IX_REPL]),
        .rep_held     (slot_v[IX_REPL]),
        .rep_id       (slot_req[IX_REPL].data[MP_ID_W-1:0]),
        .s3_done      (s3_rep_done),
        .s3_id        (s3_rep_id),
        .refill_valid (refill_valid),
        .refill_id    (refill_id),
        .refill_ready (refill_ready),
        .refill_go    (refill_go)
    );

    always_ff @(posedge clk) begin
        if (rst) resv_q <= 1'b0;
        else     resv_q <= resv_update;
    end

    always_comb begin
        elig[IX_STORE] = slot_v[IX_STORE];
        elig[IX_ATOM]  = slot_v[IX_ATOM];
        elig[IX_REPL]  = slot_v[IX_REPL] && !s1_valid;
        elig[IX_PROBE] = slot_v[IX_PROBE] && !resv_q;
        if (refill_go) elig = '0;
        grant = mp_pick_top(elig);
    end

    always_comb begin
        sel_set  = '0;
        sel_data = '0;
        for (int i = 0; i < MP_NSRC; i++) begin
            if (grant[i]) begin
                sel_set  = slot_req[i].set;
                sel_data = slot_req[i].data;
            end
        end
    end

    assign sel_valid = |grant;
    assign sel_src   = mp_src_of(grant);
    assign st_ready  = in_rdy[IX_STORE];
    assign amo_ready = in_rdy[IX_ATOM];
    assign prb_ready = in_rdy[IX_PROBE];

    // R3
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R3
    store_yields_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_valid && sel_src == SRC_STORE) |-> !slot_v[IX_ATOM]);

    // R5
    refill_blocks_all_chk: assert property (@(posedge clk) disable iff (rst)
        (refill_valid && refill_ready) |-> !sel_valid);

    // R6
    s1_blocks_repl_chk: assert property (@(posedge clk) disable iff (rst)
        s1_valid |-> !(sel_valid && sel_src == SRC_REPL));

    // R7
    resv_blocks_probe_chk: assert property (@(posedge clk) disable iff (rst)
        resv_update |=> !(sel_valid && sel_src == SRC_PROBE));

endmodule

// File: tb/mp_entry_arb_test.sv
`timescale 1ns/1ps
module mp_entry_arb_test;
    import mp_arb_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic                              st_valid, amo_valid, prb_valid;
    logic [MP_SET_W-1:0]               st_set, amo_set, prb_set;
    logic [MP_DATA_W-1:0]              st_data, amo_data, prb_data;
    logic [MP_NMISS-1:0]               miss_rep_valid;
    logic [MP_NMISS-1:0][MP_SET_W-1:0] miss_rep_set;
    logic                              refill_valid, s1_valid, s3_rep_done, resv_update;
    logic [MP_ID_W-1:0]                refill_id, s3_rep_id;
    logic                              st_ready, amo_ready, prb_ready, refill_ready, sel_valid;
    logic [MP_NMISS-1:0]               miss_rep_ready;
    logic [1:0]                        sel_src;
    logic [MP_SET_W-1:0]               sel_set;
    logic [MP_DATA_W-1:0]              sel_data;

    mp_entry_arb uut (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_ready(st_ready), .st_set(st_set), .st_data(st_data),
        .amo_valid(amo_valid), .amo_ready(amo_ready), .amo_set(amo_set), .amo_data(amo_data),
        .prb_valid(prb_valid), .prb_ready(prb_ready), .prb_set(prb_set), .prb_data(prb_data),
        .miss_rep_valid(miss_rep_valid), .miss_rep_set(miss_rep_set), .miss_rep_ready(miss_rep_ready),
        .refill_valid(refill_valid), .refill_id(refill_id), .refill_ready(refill_ready),
        .s1_valid(s1_valid), .s3_rep_done(s3_rep_done), .s3_rep_id(s3_rep_id),
        .resv_update(resv_update),
        .sel_valid(sel_valid), .sel_src(sel_src), .sel_set(sel_set), .sel_data(sel_data)
    );

    // bench model state
    logic                mv [4];
    mp_req_t             mq [4];
    logic [MP_NMISS-1:0] mpend;
    logic                mresv;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input string r, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        st_valid = 0; amo_valid = 0; prb_valid = 0;
        miss_rep_valid = '0; refill_valid = 0; s1_valid = 0;
        s3_rep_done = 0; resv_update = 0; refill_id = '0; s3_rep_id = '0;
    endtask

    // check one cycle against the model, then advance the model across the edge
    task automatic step(input int exp_src, input string tag);
        int rid, gi, pick;
        logic rrdy, rgo;
        logic [3:0] el, g, rdy, nv;
        logic [MP_NMISS-1:0] mrdy, npend;
        mp_req_t nin [4];
        string vtag;
        #5;
        rid  = int'(refill_id);
        rrdy = !mpend[rid] && !(mv[2] && int'(mq[2].data[MP_ID_W-1:0]) == rid);
        rgo  = refill_valid && rrdy;
        el[0] = mv[0];
        el[1] = mv[1];
        el[2] = mv[2] && !s1_valid;
        el[3] = mv[3] && !mresv;
        if (rgo) el = '0;
        gi = -1;
        for (int i = 3; i >= 0; i--) if (el[i] && gi < 0) gi = i;
        g = '0;
        if (gi >= 0) g[gi] = 1'b1;
        for (int i = 0; i < 4; i++) rdy[i] = !mv[i] || g[i];
        pick = -1;
        for (int i = MP_NMISS - 1; i >= 0; i--) if (miss_rep_valid[i]) pick = i;
        mrdy = '0;
        if (pick >= 0 && rdy[2]) mrdy[pick] = 1'b1;

        vtag = rgo ? "R5" : (s1_valid && mv[2]) ? "R6" : (mresv && mv[3]) ? "R7" : "R3";
        chk(vtag, "sel_valid", int'(sel_valid), int'(gi >= 0));
        if (gi >= 0) begin
            chk("R3", "sel_src", int'(sel_src), gi);
            chk("R4", "sel_set", int'(sel_set), int'(mq[gi].set));
            chk("R4", "sel_data", int'(sel_data), int'(mq[gi].data));
        end
        chk((mv[0] && g[0]) ? "R10" : "R2", "st_ready", int'(st_ready), int'(rdy[0]));
        chk((mv[1] && g[1]) ? "R10" : "R2", "amo_ready", int'(amo_ready), int'(rdy[1]));
        chk((mv[3] && g[3]) ? "R10" : "R2", "prb_ready", int'(prb_ready), int'(rdy[3]));
        chk("R8", "miss_rep_ready", int'(miss_rep_ready), int'(mrdy));
        chk("R9", "refill_ready", int'(refill_ready), int'(rrdy));
        if (exp_src >= 0)
            chk(tag, "directed source", sel_valid ? int'(sel_src) : 4, exp_src);

        nin[0].set = st_set;  nin[0].data = st_data;
        nin[1].set = amo_set; nin[1].data = amo_data;
        nin[3].set = prb_set; nin[3].data = prb_data;
        nin[2] = '0;
        if (pick >= 0) begin
            nin[2].set  = miss_rep_set[pick];
            nin[2].data = MP_DATA_W'(pick);
        end
        nv = {prb_valid, pick >= 0, amo_valid, st_valid};
        npend = mpend;
        if (s3_rep_done) npend[s3_rep_id] = 1'b0;
        if (g[2]) npend[mq[2].data[MP_ID_W-1:0]] = 1'b1;

        @(posedge clk);
        #1;
        for (int i = 0; i < 4; i++) begin
            if (nv[i] && rdy[i]) begin
                mv[i] = 1'b1;
                mq[i] = nin[i];
            end else if (g[i]) begin
                mv[i] = 1'b0;
            end
        end
        mpend = npend;
        mresv = resv_update;
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 4; i++) begin
            mv[i] = 1'b0;
            mq[i] = '0;
        end
        mpend = '0;
        mresv = 1'b0;
        idle_inputs();
        st_set = '0; amo_set = '0; prb_set = '0;
        st_data = '0; amo_data = '0; prb_data = '0;
        miss_rep_set = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #5;
        // R1 reset state
        chk("R1", "sel_valid", int'(sel_valid), 0);
        chk("R1", "st_ready", int'(st_ready), 1);
        chk("R1", "amo_ready", int'(amo_ready), 1);
        chk("R1", "prb_ready", int'(prb_ready), 1);
        chk("R1", "refill_ready", int'(refill_ready), 1);

        // load every source, with a reservation update
        @(negedge clk);
        st_valid = 1; st_set = 8'h11; st_data = 16'h1111;
        amo_valid = 1; amo_set = 8'h22; amo_data = 16'h2222;
        prb_valid = 1; prb_set = 8'h33; prb_data = 16'h3333;
        miss_rep_valid = 16'h0060; miss_rep_set[5] = 8'h55; miss_rep_set[6] = 8'h66;
        resv_update = 1;
        step(4, "R1");
        // probe blocked by reservation update, replace by stage 1: atomic wins
        @(negedge clk); idle_inputs(); s1_valid = 1;
        step(1, "R7");
        // eligible refill blocks everything
        @(negedge clk); idle_inputs(); refill_valid = 1; refill_id = 4'd9;
        step(4, "R5");
        @(negedge clk); idle_inputs();
        step(3, "R3");
        @(negedge clk); idle_inputs();
        step(2, "R6");
        // refill for entry 5 held while its replace is in flight
        @(negedge clk); idle_inputs(); refill_valid = 1; refill_id = 4'd5;
        step(0, "R9");
        @(negedge clk); idle_inputs(); refill_valid = 1; refill_id = 4'd5;
        s3_rep_done = 1; s3_rep_id = 4'd5;
        step(4, "R9");
        @(negedge clk); idle_inputs(); refill_valid = 1; refill_id = 4'd5;
        step(4, "R9");

        // seeded random traffic
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            st_valid  = ($urandom % 2) == 0;
            st_set    = MP_SET_W'($urandom);
            st_data   = MP_DATA_W'($urandom);
            amo_valid = ($urandom % 3) == 0;
            amo_set   = MP_SET_W'($urandom);
            amo_data  = MP_DATA_W'($urandom);
            prb_valid = ($urandom % 3) == 0;
            prb_set   = MP_SET_W'($urandom);
            prb_data  = MP_DATA_W'($urandom);
            miss_rep_valid = MP_NMISS'($urandom & $urandom & $urandom);
            for (int m = 0; m < MP_NMISS; m++) miss_rep_set[m] = MP_SET_W'($urandom);
            refill_valid = ($urandom % 5) == 0;
            refill_id    = MP_ID_W'($urandom);
            s1_valid     = ($urandom % 3) == 0;
            resv_update  = ($urandom % 4) == 0;
            s3_rep_done  = ($urandom % 3) == 0;
            s3_rep_id    = MP_ID_W'($urandom);
            step(-1, "");
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule